// File: doc/BRIEF.md
# Packet-to-Cell Segmenter with Minimum Burst Length

The segmenter turns one packet length into a sequence of buffer-cell descriptors. Each descriptor carries a byte offset into the packet, a cell length, and a flag that marks the final cell. The payload is split into cells no longer than a fixed maximum cell size. No cell of a multi-cell packet may be shorter than a programmed minimum, so every memory burst stays long enough to cover the row precharge and activate time of a DRAM buffer.

Where a plain split would leave a short tail, the last full cell and the tail are merged. That sum is then divided into two near-equal cells. With a 64-byte maximum and a 32-byte minimum, a 65-byte packet becomes cells of 32 and 33 bytes rather than 64 and 1.

Packet lengths arrive on a valid/ready port. Cell descriptors leave on a valid/ready port. The block takes one packet at a time: a new length is accepted only after the previous packet's final cell has been handed off.

Top module: `pkt_cell_segmenter`

## Requirements
- R1: `pkt_ready` is high exactly when no cell of an earlier packet is still pending. A length is taken on a clock edge where `pkt_valid` and `pkt_ready` are both high. The first cell of that packet appears at offset 0 on the next cycle. While cells are pending, `pkt_valid` has no effect.
- R2: A packet of 1 to MAX_CELL bytes yields exactly one cell. That cell has offset 0, its length equals the packet length, and `cell_last` is 1. This holds even when the length is below MIN_CELL.
- R3: No cell length exceeds MAX_CELL (64 by default).
- R4: In a packet of more than MAX_CELL bytes, every cell is at least MIN_CELL bytes long (32 by default).
- R5: Let R be the number of bytes still to be emitted. While R is at least MAX_CELL + MIN_CELL, the next cell is MAX_CELL bytes long.
- R6: When MAX_CELL < R < MAX_CELL + MIN_CELL, the next cell holds floor(R/2) bytes. The final cell then holds the remaining R - floor(R/2) bytes. For example, 65 bytes give cells of 32 and 33.
- R7: Offsets are cumulative. Each cell starts at the previous cell's offset plus its length. Cell lengths sum to the packet length, and only the final cell has `cell_last` = 1.
- R8: While `cell_valid` is high and `cell_ready` is low, offset, length and last flag hold their values.
- R9: After reset, `cell_valid` is 0 and `pkt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet length offered |
| pkt_ready | output | 1 | Segmenter idle, length can be taken |
| pkt_len | input | LEN_W | Packet length in bytes |
| cell_valid | output | 1 | Cell descriptor present |
| cell_ready | input | 1 | Consumer takes the descriptor |
| cell_off | output | LEN_W | Byte offset of the cell in its packet |
| cell_len | output | CLEN_W | Cell length in bytes |
| cell_last | output | 1 | Final cell of the packet |

## Verification
The assertions assume that a packet length is never zero. A zero-length packet would emit a zero-length cell and break the length bounds. They also assume MIN_CELL is no more than half of MAX_CELL; under that condition the balanced split always lands within bounds. The stimulus draws only lengths from 1 upward. These include the edges at MAX_CELL, MAX_CELL + MIN_CELL and multiples of MAX_CELL. The stimulus also holds `pkt_valid` high while cells are pending and stalls `cell_ready` at random, so that the hold rule and the ignored-request rule are both exercised.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EMIT = 1'b1
    } seg_phase_e;
endpackage

// File: rtl/seg_sizer.sv
module seg_sizer #(
    parameter int LEN_W    = 16,
    parameter int MAX_CELL = 64,
    parameter int MIN_CELL = 32,
    parameter int CLEN_W   = $clog2(MAX_CELL + 1)
) (
    input  logic [LEN_W-1:0]  rem,
    output logic [CLEN_W-1:0] len,
    output logic              last
);
    localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_CELL);
    localparam logic [LEN_W-1:0] SPLIT_L = LEN_W'(MAX_CELL + MIN_CELL);

    logic [LEN_W-1:0] half;

    always_comb begin
        half = rem >> 1;
        if (rem <= MAX_L) begin
            len  = CLEN_W'(rem);
            last = 1'b1;
        end else if (rem < SPLIT_L) begin
            // merge short tail with last full cell, then halve
            len  = CLEN_W'(half);
            last = 1'b0;
        end else begin
            len  = CLEN_W'(MAX_CELL);
            last = 1'b0;
        end
    end
endmodule

// File: rtl/seg_track.sv
module seg_track
    import seg_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int CLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_fire,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              cell_fire,
    input  logic [CLEN_W-1:0] cell_len,
    input  logic              cell_last,
    output seg_phase_e        phase,
    output logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  off
);
    typedef struct packed {
        seg_phase_e       phase;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] off;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_IDLE) begin
            if (pkt_fire) begin
                st_d.phase = PH_EMIT;
                st_d.rem   = pkt_len;
                st_d.off   = '0;
            end
        end else if (cell_fire) begin
            st_d.rem = st_q.rem - LEN_W'(cell_len);
            st_d.off = st_q.off + LEN_W'(cell_len);
            if (cell_last) begin
                st_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, rem: '0, off: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign rem   = st_q.rem;
    assign off   = st_q.off;

    // R7: a non-final handoff never empties the remaining count
    p_rem_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EMIT && cell_fire && !cell_last) |=> (phase == PH_EMIT && rem != '0));
endmodule

// File: rtl/pkt_cell_segmenter.sv
module pkt_cell_segmenter
    import seg_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int MAX_CELL = 64,
    parameter int MIN_CELL = 32,
    parameter int CLEN_W   = $clog2(MAX_CELL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              cell_valid,
    input  logic              cell_ready,
    output logic [LEN_W-1:0]  cell_off,
    output logic [CLEN_W-1:0] cell_len,
    output logic              cell_last
);
    seg_phase_e       phase;
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] off;
    logic             pkt_fire;
    logic             cell_fire;

    assign pkt_ready  = (phase == PH_IDLE);
    assign cell_valid = (phase == PH_EMIT);
    assign pkt_fire   = pkt_valid && pkt_ready;
    assign cell_fire  = cell_valid && cell_ready;
    assign cell_off   = off;

    seg_sizer #(
        .LEN_W(LEN_W), .MAX_CELL(MAX_CELL), .MIN_CELL(MIN_CELL), .CLEN_W(CLEN_W)
    ) u_sizer (
        .rem (rem),
        .len (cell_len),
        .last(cell_last)
    );

    seg_track #(
        .LEN_W(LEN_W), .CLEN_W(CLEN_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_fire (pkt_fire),
        .pkt_len  (pkt_len),
        .cell_fire(cell_fire),
        .cell_len (cell_len),
        .cell_last(cell_last),
        .phase    (phase),
        .rem      (rem),
        .off      (off)
    );

    p_first_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_fire |=> (cell_valid && cell_off == '0));

    p_single_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_fire && pkt_len <= LEN_W'(MAX_CELL)) |=>
            (cell_last && LEN_W'(cell_len) == $past(pkt_len)));

    p_len_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> (cell_len <= CLEN_W'(MAX_CELL)));

    p_len_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !(cell_off == '0 && cell_last)) |-> (cell_len >= CLEN_W'(MIN_CELL)));

    p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_fire && !cell_last) |=>
            (cell_valid && cell_off == $past(cell_off) + LEN_W'($past(cell_len))));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && !cell_ready) |=>
            (cell_valid && $stable(cell_off) && $stable(cell_len) && $stable(cell_last)));
endmodule

// File: tb/pkt_cell_segmenter_bench.sv
module pkt_cell_segmenter_bench;
    localparam int LEN_W    = 16;
    localparam int MAX_CELL = 64;
    localparam int MIN_CELL = 32;
    localparam int CLEN_W   = $clog2(MAX_CELL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_valid = 1'b0;
    logic              pkt_ready;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic              cell_valid;
    logic              cell_ready = 1'b0;
    logic [LEN_W-1:0]  cell_off;
    logic [CLEN_W-1:0] cell_len;
    logic              cell_last;

    always #2.5 clk = ~clk;

    pkt_cell_segmenter #(
        .LEN_W(LEN_W), .MAX_CELL(MAX_CELL), .MIN_CELL(MIN_CELL), .CLEN_W(CLEN_W)
    ) u_pkt_cell_segmenter (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .cell_valid(cell_valid), .cell_ready(cell_ready),
        .cell_off(cell_off), .cell_len(cell_len), .cell_last(cell_last)
    );

    int errors = 0;
    int checks = 0;
    int q_off[$];
    int q_len[$];
    int q_last[$];
    int lens[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected cells from the length arithmetic of R2, R5, R6
    task automatic plan_packet(input int len);
        int nfull, tail, o, s;
        o = 0;
        nfull = len / MAX_CELL;
        tail  = len % MAX_CELL;
        if (len <= MAX_CELL) begin
            q_off.push_back(0); q_len.push_back(len); q_last.push_back(1);
        end else if (tail == 0 || tail >= MIN_CELL) begin
            for (int i = 0; i < nfull; i++) begin
                q_off.push_back(o); q_len.push_back(MAX_CELL);
                q_last.push_back((tail == 0 && i == nfull - 1) ? 1 : 0);
                o += MAX_CELL;
            end
            if (tail != 0) begin
                q_off.push_back(o); q_len.push_back(tail); q_last.push_back(1);
            end
        end else begin
            for (int i = 0; i < nfull - 1; i++) begin
                q_off.push_back(o); q_len.push_back(MAX_CELL); q_last.push_back(0);
                o += MAX_CELL;
            end
            s = MAX_CELL + tail;
            q_off.push_back(o); q_len.push_back(s / 2); q_last.push_back(0);
            q_off.push_back(o + s / 2); q_len.push_back(s - s / 2); q_last.push_back(1);
        end
    endtask

    int cyc = 0;
    int idx = 0;
    bit prev_stall = 1'b0;
    bit timeout = 1'b0;

    initial begin
        lens = '{1, 20, 32, 64, 65, 95, 96, 100, 128, 129, 150, 160, 191, 200, 1000, 63, 2};
        for (int k = 0; k < 30; k++) lens.push_back(1 + int'($urandom % 700));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cell_valid == 1'b0, "R9 cell_valid after reset", int'(cell_valid), 0);
        check(pkt_ready == 1'b1, "R9 pkt_ready after reset", int'(pkt_ready), 1);
        rst_n = 1'b1;

        while (idx < lens.size() || q_len.size() != 0) begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                timeout = 1'b1;
                break;
            end
            // compare outputs to the model on every cycle
            check(pkt_ready == (q_len.size() == 0), "R1 pkt_ready", int'(pkt_ready),
                  int'(q_len.size() == 0));
            check(cell_valid == (q_len.size() != 0), "R1 cell_valid", int'(cell_valid),
                  int'(q_len.size() != 0));
            if (cell_valid && q_len.size() != 0) begin
                check(int'(cell_off) == q_off[0], prev_stall ? "R8 held offset" : "R7 offset",
                      int'(cell_off), q_off[0]);
                check(int'(cell_len) == q_len[0],
                      prev_stall ? "R8 held length" : "R5/R6 length (R2 R3 R4)",
                      int'(cell_len), q_len[0]);
                check(int'(cell_last) == q_last[0], "R7 last flag", int'(cell_last), q_last[0]);
            end
            // drive next inputs; request stays up while busy to exercise R1
            pkt_valid  = (idx < lens.size());
            pkt_len    = (idx < lens.size()) ? LEN_W'(lens[idx]) : '0;
            cell_ready = (idx < 20) ? 1'b1 : (($urandom % 3) != 0);
            prev_stall = cell_valid && !cell_ready;
            if (cell_valid && cell_ready && q_len.size() != 0) begin
                void'(q_off.pop_front()); void'(q_len.pop_front()); void'(q_last.pop_front());
            end
            if (pkt_valid && pkt_ready) begin
                plan_packet(lens[idx]);
                idx++;
            end
        end
        if (timeout) check(1'b0, "watchdog", cyc, 100000);
        @(negedge clk);
        pkt_valid = 1'b0;
        check(pkt_ready == 1'b1, "R1 idle at end", int'(pkt_ready), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule